// File: doc/BRIEF.md
# Regulator Fault Counter Supervisor

This block supervises a set of regulated supply rails from digital fault flags. Each rail reports undervoltage. The memory rail also reports overcurrent and overvoltage. The termination rail also reports overvoltage. The block drives one disable per rail and a latched global shutdown.

An overvoltage on the memory or termination rail trips the global shutdown at once. Every other fault turns off only its own rail and adds one to a fault count. A rail whose upstream supply has been turned off is treated as faulted too, and it is counted. A fault-reset timer advances on a slow tick enable. After a long run of fault-free ticks, the timer empties the count. While a restart from the deep-sleep state is in progress, a count at the threshold forces global shutdown.

Every latch in the block is released when the deep-sleep input goes low and then returns high. This covers the shutdown, the rail disables, the count and the timer.

Top module: `rail_fault_supervisor`

## Requirements
- R1: After reset, every `rail_off` bit and `shutdown` are low.
- R2: If `ov_mem` or `ov_term` is high at a clock edge, `shutdown` is high after that edge and all `rail_off` bits read high. Both stay high after the overvoltage is removed.
- R3: An undervoltage on any enabled rail turns on that rail's `rail_off` bit at the next edge and adds one to the fault count. So does an overcurrent (`oc_mem`) on the memory rail (index `MEM_IDX`, default 0). No other rail's bit changes.
- R4: Faults are counted on rising edges of the flags. A flag held high counts once. A flag that is still high when the latches are released does not fault its rail again until it falls and rises once more.
- R5: Bit `d*N_RAIL+u` of `feed_map` marks rail `u` as the supply of rail `d`. One edge after rail `u` is disabled, an enabled rail `d` is disabled as well and adds one to the count.
- R6: Every fault restarts the reset timer at zero. The timer advances only on edges where `tick` is high. At the `CLR_TICKS`-th tick after the last fault (default 16384), the count returns to zero. A fault that lands on that same edge wins, and it is added to the uncleared count.
- R7: While `restart_s5` is high, a count that reaches `SHUT_COUNT` (default 4) latches `shutdown` at the edge where it gets there.
- R8: `shutdown` and the rail disables hold while `s5_n` is low. They are released, together with the count and the timer, at the edge where `s5_n` is seen high after being low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timer enable, one cycle per 4 us tick |
| uv_flag | input | N_RAIL | Undervoltage flag per rail |
| oc_mem | input | 1 | Overcurrent flag of the memory rail |
| ov_mem | input | 1 | Overvoltage flag of the memory rail |
| ov_term | input | 1 | Overvoltage flag of the termination rail |
| feed_map | input | N_RAIL*N_RAIL | Supply map; bit d*N_RAIL+u set when rail u feeds rail d |
| s5_n | input | 1 | Low while in the deep-sleep state |
| restart_s5 | input | 1 | High while restarting from deep sleep |
| rail_off | output | N_RAIL | Per-rail disable (all high under shutdown) |
| shutdown | output | 1 | Latched global shutdown |

## Verification
Two events can fall on the same edge: the timer emptying the count and a new fault arriving.

The bench raises three faults at once with `restart_s5` high. It then places a fourth fault at 16383, 16384 and 16385 ticks after them. The expected count is 3+1 when the fault falls on or before the clearing edge, and 0+1 when it falls after it. Only the first two cases cross the threshold, so `shutdown` one edge later tells which event won.

A fourth run holds `tick` low and confirms that the count survives.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

   // saturating add used by the fault tally
   function automatic int sat_add(input int a, input int b, input int lim);
      return (a + b > lim) ? lim : a + b;
   endfunction

endpackage

// File: rtl/rfs_event.sv
module rfs_event #(
   parameter int N_RAIL  = 4,
   parameter int MEM_IDX = 0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [N_RAIL-1:0]        uv_flag,
   input  logic                     oc_mem,
   input  logic [N_RAIL-1:0]        off_q,
   input  logic [N_RAIL*N_RAIL-1:0] feed_map,
   output logic [N_RAIL-1:0]        evt
);

   logic [N_RAIL-1:0] flag, flag_q, casc;

   for (genvar i = 0; i < N_RAIL; i++) begin : g_rail
      if (i == MEM_IDX) begin : g_mem
         assign flag[i] = uv_flag[i] | oc_mem;
      end else begin : g_plain
         assign flag[i] = uv_flag[i];
      end
      // loss of input: any disabled supplier of this rail, self excluded
      assign casc[i] = |(feed_map[i*N_RAIL +: N_RAIL] & off_q & ~(N_RAIL'(1) << i));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= '0;
      else        flag_q <= flag;
   end

   assign evt = ((flag & ~flag_q) | casc) & ~off_q;

endmodule

// File: rtl/rfs_tally.sv
module rfs_tally #(
   parameter int CNT_W     = 3,
   parameter int CLR_TICKS = 16384,
   parameter int SHUT_COUNT = 4,
   parameter int EW        = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          tick,
   input  logic          restart,
   input  logic [EW-1:0] n_evt,
   output logic          over
);

   localparam int TW = (CLR_TICKS > 2) ? $clog2(CLR_TICKS) : 1;
   localparam int CMAX = (1 << CNT_W) - 1;
   localparam logic [TW-1:0]    TLAST = TW'(CLR_TICKS - 1);
   localparam logic [CNT_W-1:0] THR   = CNT_W'(SHUT_COUNT);

   if (CLR_TICKS < 2) begin : g_bad_ticks
      $error("CLR_TICKS must be at least 2");
   end
   if (SHUT_COUNT < 1 || SHUT_COUNT > CMAX) begin : g_bad_thr
      $error("SHUT_COUNT must fit in CNT_W bits");
   end

   logic [CNT_W-1:0] cnt_q, cnt_n;
   logic [TW-1:0]    tmr_q, tmr_n;

   always_comb begin
      cnt_n = cnt_q;
      tmr_n = tmr_q;
      if (clr) begin
         cnt_n = '0;
         tmr_n = '0;
      end else if (n_evt != '0) begin
         cnt_n = CNT_W'(rfs_pkg::sat_add(int'(cnt_q), int'(n_evt), CMAX));
         tmr_n = '0;
      end else if (tick && cnt_q != '0) begin
         if (tmr_q == TLAST) begin
            cnt_n = '0;
            tmr_n = '0;
         end else begin
            tmr_n = tmr_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         tmr_q <= '0;
      end else begin
         cnt_q <= cnt_n;
         tmr_q <= tmr_n;
      end
   end

   assign over = restart && (cnt_n >= THR);

   assert_tmr_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && n_evt == '0 && tick && cnt_q != '0 && tmr_q == TLAST) |=> (cnt_q == '0));
   assert_evt_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && n_evt != '0) |=> (tmr_q == '0 && cnt_q != '0));
   assert_no_tick_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && n_evt == '0 && !tick) |=> ($stable(cnt_q) && $stable(tmr_q)));
   assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q == '0 && tmr_q == '0));

endmodule

// File: rtl/rail_fault_supervisor.sv
module rail_fault_supervisor #(
   parameter int N_RAIL     = 4,
   parameter int MEM_IDX    = 0,
   parameter int TERM_IDX   = 1,
   parameter int CNT_W      = 3,
   parameter int CLR_TICKS  = 16384,
   parameter int SHUT_COUNT = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     tick,
   input  logic [N_RAIL-1:0]        uv_flag,
   input  logic                     oc_mem,
   input  logic                     ov_mem,
   input  logic                     ov_term,
   input  logic [N_RAIL*N_RAIL-1:0] feed_map,
   input  logic                     s5_n,
   input  logic                     restart_s5,
   output logic [N_RAIL-1:0]        rail_off,
   output logic                     shutdown
);

   localparam int EW = $clog2(N_RAIL + 1);

   if (N_RAIL < 2 || MEM_IDX >= N_RAIL || TERM_IDX >= N_RAIL || MEM_IDX == TERM_IDX)
   begin : g_bad_idx
      $error("rail indices out of range or equal");
   end

   logic [N_RAIL-1:0] off_q, evt;
   logic              shut_q, s5_q, s5_rise, over, ov_any;

   assign s5_rise = s5_n && !s5_q;
   assign ov_any  = ov_mem || ov_term;

   rfs_event #(.N_RAIL(N_RAIL), .MEM_IDX(MEM_IDX)) u_event (
      .clk     (clk),
      .rst_n   (rst_n),
      .uv_flag (uv_flag),
      .oc_mem  (oc_mem),
      .off_q   (off_q),
      .feed_map(feed_map),
      .evt     (evt)
   );

   rfs_tally #(.CNT_W(CNT_W), .CLR_TICKS(CLR_TICKS), .SHUT_COUNT(SHUT_COUNT), .EW(EW)) u_tally (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (s5_rise),
      .tick   (tick),
      .restart(restart_s5),
      .n_evt  (EW'($countones(evt))),
      .over   (over)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         off_q  <= '0;
         shut_q <= 1'b0;
         s5_q   <= 1'b1;
      end else begin
         s5_q   <= s5_n;
         off_q  <= s5_rise ? '0 : (off_q | evt);
         if (ov_any || over) shut_q <= 1'b1;
         else if (s5_rise)   shut_q <= 1'b0;
      end
   end

   assign rail_off = off_q | {N_RAIL{shut_q}};
   assign shutdown = shut_q;

   assert_ov_trip_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ov_any |=> (shutdown && (&rail_off)));
   assert_shut_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (shut_q && !s5_rise) |=> shut_q);
   assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (s5_rise && !ov_any) |=> (!shut_q && off_q == '0));

   for (genvar d = 0; d < N_RAIL; d++) begin : g_chk
      assert_off_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (off_q[d] && !s5_rise) |=> off_q[d]);
      for (genvar u = 0; u < N_RAIL; u++) begin : g_pair
         assert_cascade_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (off_q[u] && feed_map[d*N_RAIL+u] && !s5_rise) |=> off_q[d]);
      end
   end

endmodule

// File: tb/sim_rail_fault_supervisor.sv
`timescale 1ns/1ps
module sim_rail_fault_supervisor;

   localparam int N = 4;
   localparam int LIMIT = 16384;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         tick = 1'b1;
   logic [N-1:0] uv_flag = '0;
   logic         oc_mem = 1'b0, ov_mem = 1'b0, ov_term = 1'b0;
   logic [N*N-1:0] feed_map = '0;
   logic         s5_n = 1'b1, restart_s5 = 1'b0;
   logic [N-1:0] rail_off;
   logic         shutdown;

   int checks = 0;
   int fails  = 0;

   rail_fault_supervisor u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .uv_flag(uv_flag), .oc_mem(oc_mem),
      .ov_mem(ov_mem), .ov_term(ov_term), .feed_map(feed_map), .s5_n(s5_n),
      .restart_s5(restart_s5), .rail_off(rail_off), .shutdown(shutdown)
   );

   always #4 clk = ~clk;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic adv(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic release_s5();
      s5_n = 1'b0;
      adv(2);
      s5_n = 1'b1;
      adv(1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      adv(1);
      chk("R1 reset rail_off", 32'(rail_off), 0);
      chk("R1 reset shutdown", 32'(shutdown), 0);

      // R3: single rail undervoltage, held high
      uv_flag[2] = 1'b1;
      adv(1);
      chk("R3 uv rail2", 32'(rail_off), 32'h4);
      adv(3);
      chk("R3 uv held", 32'(rail_off), 32'h4);
      oc_mem = 1'b1;
      adv(1);
      chk("R3 oc memory rail", 32'(rail_off), 32'h5);
      oc_mem = 1'b0;

      // R7: count 3 then 4 during restart
      restart_s5 = 1'b1;
      uv_flag[3] = 1'b1;
      adv(1);
      chk("R7 count3 no shutdown", 32'(shutdown), 0);
      chk("R7 count3 rails", 32'(rail_off), 32'hD);
      uv_flag[1] = 1'b1;
      adv(1);
      chk("R7 count4 shutdown", 32'(shutdown), 1);
      chk("R7 shutdown all rails", 32'(rail_off), 32'hF);

      // R8: hold in S5, release on return; uv2 stays high (R4)
      uv_flag = 4'b0100;
      restart_s5 = 1'b0;
      s5_n = 1'b0;
      adv(3);
      chk("R8 held during s5", 32'(shutdown), 1);
      s5_n = 1'b1;
      adv(1);
      chk("R8 released shutdown", 32'(shutdown), 0);
      chk("R8 released rails", 32'(rail_off), 0);
      adv(2);
      chk("R4 held flag no refault", 32'(rail_off), 0);

      // R4: count is 0, three new faults give 3, re-edge of rail2 gives 4
      restart_s5 = 1'b1;
      uv_flag = 4'b1111 & ~4'b0100 | 4'b0100;
      adv(1);
      chk("R4 held flag not counted", 32'(shutdown), 0);
      uv_flag[2] = 1'b0;
      adv(1);
      uv_flag[2] = 1'b1;
      adv(1);
      chk("R4 new edge counted", 32'(shutdown), 1);
      uv_flag = '0;
      restart_s5 = 1'b0;
      release_s5();

      // R2: overvoltage on each monitored rail
      for (int k = 0; k < 2; k++) begin
         if (k == 0) ov_mem = 1'b1; else ov_term = 1'b1;
         adv(1);
         chk("R2 ov trip", 32'(shutdown), 1);
         chk("R2 ov all rails", 32'(rail_off), 32'hF);
         ov_mem = 1'b0;
         ov_term = 1'b0;
         adv(2);
         chk("R2 ov latched", 32'(shutdown), 1);
         release_s5();
         chk("R8 ov released", 32'(shutdown), 0);
      end

      // R5: rail0 feeds rail1, rail1 feeds rail3
      feed_map = '0;
      feed_map[1*N+0] = 1'b1;
      feed_map[3*N+1] = 1'b1;
      uv_flag[0] = 1'b1;
      adv(1);
      chk("R5 source off", 32'(rail_off), 32'h1);
      adv(1);
      chk("R5 first cascade", 32'(rail_off), 32'h3);
      adv(1);
      chk("R5 second cascade", 32'(rail_off), 32'hB);
      restart_s5 = 1'b1;
      adv(1);
      chk("R5 cascade count 3", 32'(shutdown), 0);
      uv_flag[2] = 1'b1;
      adv(1);
      chk("R5 cascade count 4", 32'(shutdown), 1);
      uv_flag = '0;
      feed_map = '0;
      restart_s5 = 1'b0;
      release_s5();

      // R6: fourth fault at or around the clearing edge
      for (int k = LIMIT - 1; k <= LIMIT + 1; k++) begin
         int exp_cnt;
         exp_cnt = (k <= LIMIT) ? 3 + 1 : 1;
         restart_s5 = 1'b1;
         uv_flag = 4'b0111;
         @(posedge clk);
         repeat (k - 1) @(posedge clk);
         @(negedge clk);
         chk("R6 before fourth fault", 32'(shutdown), 0);
         uv_flag[3] = 1'b1;
         adv(1);
         chk("R6 timer boundary", 32'(shutdown), 32'(exp_cnt >= 4));
         uv_flag = '0;
         restart_s5 = 1'b0;
         release_s5();
      end

      // R6: no tick, no clearing
      tick = 1'b0;
      restart_s5 = 1'b1;
      uv_flag = 4'b0111;
      adv(LIMIT + 2000);
      chk("R6 no tick keeps count", 32'(shutdown), 0);
      uv_flag[3] = 1'b1;
      adv(1);
      chk("R6 no tick count 4", 32'(shutdown), 1);
      tick = 1'b1;

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule